// File: doc/BRIEF.md
# Clock and Reset Bring-Up Sequencer

This block is a hardware state machine that brings the clock tree of a chip up after power-on and then lets the devices out of reset in a safe order. It is started once, by a pulse on `start`. It programs four PLLs in a fixed order: core, DDR, peripheral and Ethernet. For each one it writes a packed configuration word, waits until the PLL reports lock, and only then lets the PLL's consumers use that clock again. A PLL whose bit in the presence mask is clear is skipped.

Before a PLL is reprogrammed, its consumers are protected. The core clock and the peripheral clock are parked on the reference clock through their mux selects. The DDR and Ethernet clocks have their output gates closed instead. Once the core clock is running, every device reset is asserted. The DDR resets are then released in two stages, with a settle wait after the second stage. After the peripheral and Ethernet clocks are up, the Ethernet reset is released last.

Every timed wait, including the lock timeout, uses one shared down-counter. If a PLL does not lock in time, the sequence stops and a sticky error flag is set.

Top module: `boot_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are in their idle state: `done`, `err`, `core_sel`, `per_sel`, `pll_gate`, `dev_rst_n` and `cfg_we` are all 0.
- R2: Each configuration write pulses exactly one bit of `cfg_we` (bit 0 core, 1 DDR, 2 peripheral, 3 Ethernet) for one cycle. During that cycle `cfg_data` carries that PLL's parameter word with bit 31 forced to 0. The word layout is: reference divider [5:0], feedback divider [14:6], output divider [17:15], filter range [20:18], bypass [24], internal-feedback select [25], lock flag [31] (read-only, so it is written as 0).
- R3: `core_sel` goes to 1 (reference clock) before the core PLL is written. It returns to 0 only after the core lock input has been seen high. If the core PLL is absent, `core_sel` stays at 1.
- R4: After a configuration write, the sequence does not advance until that PLL's lock input is 1.
- R5: A PLL whose presence bit is 0 gets no configuration write, and its gate or select output is left untouched. The presence bits are: 5 core, 2 DDR, 3 peripheral, 1 Ethernet. Bits 0 and 4 are ignored.
- R6: `pll_gate[0]` (DDR) and `pll_gate[2]` (Ethernet) are 0 whenever their PLL is written. Each gate rises only after the matching lock input has been seen high.
- R7: After the core step, `dev_rst_n` is cleared to 0 before any DDR action.
- R8: The DDR resets are released in order. Bit 0 (controller) is released first. Bits 1, 2 and 3 (AXI, AHB, PHY) are released together in a later cycle. Nothing else happens for at least `DDR_SETTLE` cycles after that.
- R9: For the peripheral PLL, the sequence is: `per_sel` goes to 1, the PLL is written, lock is awaited, and `pll_gate[1]` rises. `per_sel` returns to 0 at least `PER_SETTLE` cycles after the gate rises.
- R10: `dev_rst_n[5]` (Ethernet) is released last, and only when the Ethernet gate is open or the Ethernet PLL is absent. Bits 4 and 6 stay 0.
- R11: A lock wait that lasts more than `LOCK_TMO` cycles sets `err`. `err` stays set until reset. The sequence halts: there are no further writes or releases, and `start` is ignored.
- R12: `done` rises when the sequence completes and holds until `start` is pulsed in the idle state. A `start` pulse during a run has no effect. A `start` pulse from idle re-runs the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the sequence when idle |
| pll_present | input | 6 | PLL presence mask |
| pll_lock | input | 4 | Lock flags: core, DDR, peripheral, Ethernet |
| cfg_we | output | 4 | One-hot configuration write strobe per PLL |
| cfg_data | output | 32 | Configuration word for the strobed PLL |
| core_sel | output | 1 | Core clock mux select, 1 = reference clock |
| per_sel | output | 1 | Peripheral clock mux select, 1 = reference clock |
| pll_gate | output | 3 | Output gates: DDR, peripheral, Ethernet |
| dev_rst_n | output | 7 | Active-low device resets |
| done | output | 1 | Sequence complete |
| err | output | 1 | Sticky lock-timeout error |

## Verification
The assertions take three things about the inputs for granted.
- The presence mask does not change during a run.
- A PLL's lock input drops no later than the cycle after its configuration write.
- Once a lock input has risen, it stays high until the next write to that PLL.

The bench models each PLL to match these assumptions. Its lock model clears a PLL's lock on the write strobe and raises it again after a programmed delay. The bench changes the presence mask only while reset is asserted, between runs. The timeout case holds one lock input low for good, instead of toggling it.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    PLL_CORE = 2'd0,
    PLL_DDR  = 2'd1,
    PLL_PER  = 2'd2,
    PLL_ETH  = 2'd3
  } pll_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PLL_PREP,
    S_PLL_WR,
    S_PLL_LOCK,
    S_PLL_POST,
    S_RST_ALL,
    S_DDR_CTRL,
    S_DDR_BUS,
    S_DDR_WAIT,
    S_PER_WAIT,
    S_PER_SWITCH,
    S_ETH_REL,
    S_ERR
  } state_e;

  localparam int NUM_PLL  = 4;
  localparam int PRES_W   = 6;
  localparam int RST_W    = 7;
  localparam int GATE_W   = 3;

  // Presence-mask bit for each PLL, indexed by pll_e.
  localparam int unsigned PRES_POS [NUM_PLL] = '{5, 2, 3, 1};

  // Device reset bit positions.
  localparam int RST_DDR_CTRL = 0;
  localparam int RST_DDR_AXI  = 1;
  localparam int RST_DDR_PHY  = 3;
  localparam int RST_ETH      = 5;

  localparam int CFG_LOCK_BIT = 31;

  function automatic logic [31:0] pack_cfg(input int unsigned refdiv, input int unsigned fbdiv,
                                           input int unsigned outdiv, input int unsigned rng,
                                           input int unsigned byp, input int unsigned intfb);
    logic [31:0] w;
    w        = '0;
    w[5:0]   = refdiv[5:0];
    w[14:6]  = fbdiv[8:0];
    w[17:15] = outdiv[2:0];
    w[20:18] = rng[2:0];
    w[24]    = byp[0];
    w[25]    = intfb[0];
    return w;
  endfunction

  function automatic int cnt_bits(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/boot_seq_timer.sv
module boot_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
#(
  parameter logic [31:0] CORE_WORD  = 32'h0,
  parameter logic [31:0] DDR_WORD   = 32'h0,
  parameter logic [31:0] PER_WORD   = 32'h0,
  parameter logic [31:0] ETH_WORD   = 32'h0,
  parameter int          LOCK_TMO   = 4096,
  parameter int          DDR_SETTLE = 256,
  parameter int          PER_SETTLE = 1024,
  parameter int          CNT_W      = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_PLL-1:0]  present_v,
  input  logic [NUM_PLL-1:0]  pll_lock,
  input  logic                tmr_zero,
  output logic                tmr_load,
  output logic [CNT_W-1:0]    tmr_val,
  output logic [NUM_PLL-1:0]  cfg_we,
  output logic [31:0]         cfg_data,
  output logic                core_sel,
  output logic                per_sel,
  output logic [GATE_W-1:0]   pll_gate,
  output logic [RST_W-1:0]    dev_rst_n,
  output logic                done,
  output logic                err
);

  localparam logic [NUM_PLL-1:0][31:0] WORDS = {ETH_WORD, PER_WORD, DDR_WORD, CORE_WORD};
  localparam logic [31:0] WR_MASK = ~(32'd1 << CFG_LOCK_BIT);

  state_e state_q, state_d;
  pll_e   cur_q, cur_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_PLL_PREP;
          cur_d   = PLL_CORE;
        end
      end
      S_PLL_PREP: begin
        if (present_v[cur_q]) begin
          state_d = S_PLL_WR;
        end else begin
          unique case (cur_q)
            PLL_CORE: state_d = S_RST_ALL;
            PLL_DDR:  state_d = S_DDR_CTRL;
            PLL_PER:  begin state_d = S_PLL_PREP; cur_d = PLL_ETH; end
            default:  state_d = S_ETH_REL;
          endcase
        end
      end
      S_PLL_WR: begin
        state_d  = S_PLL_LOCK;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LOCK_TMO);
      end
      S_PLL_LOCK: begin
        if (pll_lock[cur_q]) begin
          state_d = S_PLL_POST;
        end else if (tmr_zero) begin
          state_d = S_ERR;
        end
      end
      S_PLL_POST: begin
        unique case (cur_q)
          PLL_CORE: state_d = S_RST_ALL;
          PLL_DDR:  state_d = S_DDR_CTRL;
          PLL_PER:  begin
            state_d  = S_PER_WAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PER_SETTLE);
          end
          default:  state_d = S_ETH_REL;
        endcase
      end
      S_RST_ALL: begin
        state_d = S_PLL_PREP;
        cur_d   = PLL_DDR;
      end
      S_DDR_CTRL: state_d = S_DDR_BUS;
      S_DDR_BUS: begin
        state_d  = S_DDR_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(DDR_SETTLE);
      end
      S_DDR_WAIT: begin
        if (tmr_zero) begin
          state_d = S_PLL_PREP;
          cur_d   = PLL_PER;
        end
      end
      S_PER_WAIT: begin
        if (tmr_zero) state_d = S_PER_SWITCH;
      end
      S_PER_SWITCH: begin
        state_d = S_PLL_PREP;
        cur_d   = PLL_ETH;
      end
      S_ETH_REL: state_d = S_IDLE;
      S_ERR:     state_d = S_ERR;
      default:   state_d = S_IDLE;
    endcase
  end

  // Write port decode
  always_comb begin
    cfg_we   = '0;
    cfg_data = '0;
    if (state_q == S_PLL_WR) begin
      cfg_we   = NUM_PLL'(1) << cur_q;
      cfg_data = WORDS[cur_q] & WR_MASK;
    end
  end

  // Clock enables for the control registers
  logic prep_en, post_en, idle_go, err_set;
  assign prep_en = (state_q == S_PLL_PREP);
  assign post_en = (state_q == S_PLL_POST);
  assign idle_go = (state_q == S_IDLE) && start;
  assign err_set = (state_q == S_PLL_LOCK) && (state_d == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_q     <= PLL_CORE;
      core_sel  <= 1'b0;
      per_sel   <= 1'b0;
      pll_gate  <= '0;
      dev_rst_n <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      if (idle_go) done <= 1'b0;
      if (prep_en) begin
        if (cur_q == PLL_CORE) begin
          core_sel <= 1'b1;
        end else if (present_v[cur_q]) begin
          unique case (cur_q)
            PLL_DDR: pll_gate[0] <= 1'b0;
            PLL_PER: per_sel     <= 1'b1;
            default: pll_gate[2] <= 1'b0;
          endcase
        end
      end
      if (post_en) begin
        unique case (cur_q)
          PLL_CORE: core_sel    <= 1'b0;
          PLL_DDR:  pll_gate[0] <= 1'b1;
          PLL_PER:  pll_gate[1] <= 1'b1;
          default:  pll_gate[2] <= 1'b1;
        endcase
      end
      if (state_q == S_RST_ALL) dev_rst_n <= '0;
      if (state_q == S_DDR_CTRL) dev_rst_n[RST_DDR_CTRL] <= 1'b1;
      if (state_q == S_DDR_BUS) dev_rst_n[RST_DDR_PHY:RST_DDR_AXI] <= '1;
      if (state_q == S_PER_SWITCH) per_sel <= 1'b0;
      if (state_q == S_ETH_REL) begin
        dev_rst_n[RST_ETH] <= 1'b1;
        done               <= 1'b1;
      end
      if (err_set) err <= 1'b1;
    end
  end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter logic [31:0] CORE_WORD  = pack_cfg(0, 76, 2, 4, 0, 1),
  parameter logic [31:0] DDR_WORD   = pack_cfg(0, 71, 2, 4, 0, 1),
  parameter logic [31:0] PER_WORD   = pack_cfg(1, 39, 2, 4, 0, 1),
  parameter logic [31:0] ETH_WORD   = pack_cfg(0, 76, 5, 4, 0, 1),
  parameter int          LOCK_TMO   = 4096,
  parameter int          DDR_SETTLE = 256,
  parameter int          PER_SETTLE = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  pll_present,
  input  logic [3:0]  pll_lock,
  output logic [3:0]  cfg_we,
  output logic [31:0] cfg_data,
  output logic        core_sel,
  output logic        per_sel,
  output logic [2:0]  pll_gate,
  output logic [6:0]  dev_rst_n,
  output logic        done,
  output logic        err
);

  localparam int CNT_W = cnt_bits(LOCK_TMO, DDR_SETTLE, PER_SETTLE);

  logic [NUM_PLL-1:0] present_v;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               unused_pres;

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pres
    assign present_v[i] = pll_present[PRES_POS[i]];
  end

  assign unused_pres = pll_present[0] ^ pll_present[4];

  boot_seq_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  boot_seq_fsm #(
    .CORE_WORD  (CORE_WORD),
    .DDR_WORD   (DDR_WORD),
    .PER_WORD   (PER_WORD),
    .ETH_WORD   (ETH_WORD),
    .LOCK_TMO   (LOCK_TMO),
    .DDR_SETTLE (DDR_SETTLE),
    .PER_SETTLE (PER_SETTLE),
    .CNT_W      (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .present_v (present_v),
    .pll_lock  (pll_lock),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cfg_we    (cfg_we),
    .cfg_data  (cfg_data),
    .core_sel  (core_sel),
    .per_sel   (per_sel),
    .pll_gate  (pll_gate),
    .dev_rst_n (dev_rst_n),
    .done      (done),
    .err       (err)
  );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [5:0]  pll_present,
  input logic [3:0]  pll_lock,
  input logic [3:0]  cfg_we,
  input logic        core_sel,
  input logic        per_sel,
  input logic [2:0]  pll_gate,
  input logic [6:0]  dev_rst_n,
  input logic        done,
  input logic        err
);

  p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_we));

  p_core_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[0] |-> core_sel);

  p_core_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_sel) |-> $past(pll_lock[0]));

  p_ddr_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[1] |-> !pll_gate[0]);

  p_eth_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[3] |-> !pll_gate[2]);

  p_ddr_gate_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_gate[0]) |-> $past(pll_lock[1]));

  p_rst_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[1] |-> (dev_rst_n == 7'd0));

  p_ddr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n[1]) |-> $past(dev_rst_n[0]));

  p_per_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[2] |-> per_sel);

  p_per_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_sel) |-> pll_gate[1]);

  p_eth_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n[5]) |-> (pll_gate[2] || !pll_present[1]));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cfg_we == 4'd0));

  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));

endmodule

bind boot_seq boot_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pll_present (pll_present),
  .pll_lock    (pll_lock),
  .cfg_we      (cfg_we),
  .core_sel    (core_sel),
  .per_sel     (per_sel),
  .pll_gate    (pll_gate),
  .dev_rst_n   (dev_rst_n),
  .done        (done),
  .err         (err)
);

// File: tb/boot_seq_tb_top.sv
module boot_seq_tb_top;

  localparam int LOCK_TMO   = 200;
  localparam int DDR_SETTLE = 256;
  localparam int PER_SETTLE = 40;

  // Words built from the R2 field layout; DDR word has bit 31 set to test its clearing.
  localparam logic [31:0] W_CORE = (32'd76 << 6) | (32'd2 << 15) | (32'd4 << 18) | (32'd1 << 25);
  localparam logic [31:0] W_DDR  = (32'd71 << 6) | (32'd2 << 15) | (32'd4 << 18) | (32'd1 << 25)
                                   | (32'd1 << 31);
  localparam logic [31:0] W_PER  = 32'd1 | (32'd39 << 6) | (32'd2 << 15) | (32'd4 << 18)
                                   | (32'd1 << 25);
  localparam logic [31:0] W_ETH  = (32'd76 << 6) | (32'd5 << 15) | (32'd4 << 18) | (32'd1 << 24)
                                   | (32'd1 << 25);
  localparam logic [6:0]  RST_FINAL = 7'b0101111;

  typedef struct packed {
    logic [5:0] mask;
    logic [7:0] dly;
    logic [3:0] we;
    logic [2:0] gate;
    logic       cs;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'b111111, 8'd3,  4'b1111, 3'b111, 1'b0},
    '{6'b000000, 8'd5,  4'b0000, 3'b000, 1'b1},
    '{6'b100100, 8'd7,  4'b0011, 3'b001, 1'b0},
    '{6'b001010, 8'd1,  4'b1100, 3'b110, 1'b1},
    '{6'b010001, 8'd2,  4'b0000, 3'b000, 1'b1},
    '{6'b101110, 8'd60, 4'b1111, 3'b111, 1'b0}
  };

  logic        clk, rst_n, start;
  logic [5:0]  pll_present;
  logic [3:0]  pll_lock;
  logic [3:0]  cfg_we;
  logic [31:0] cfg_data;
  logic        core_sel, per_sel, done, err;
  logic [2:0]  pll_gate;
  logic [6:0]  dev_rst_n;

  boot_seq #(
    .CORE_WORD (W_CORE), .DDR_WORD (W_DDR), .PER_WORD (W_PER), .ETH_WORD (W_ETH),
    .LOCK_TMO (LOCK_TMO), .DDR_SETTLE (DDR_SETTLE), .PER_SETTLE (PER_SETTLE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .pll_present (pll_present),
    .pll_lock (pll_lock), .cfg_we (cfg_we), .cfg_data (cfg_data), .core_sel (core_sel),
    .per_sel (per_sel), .pll_gate (pll_gate), .dev_rst_n (dev_rst_n), .done (done), .err (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // PLL lock model
  int  lock_dly;
  bit  eth_stuck;
  int  lcnt [4];
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) begin
        pll_lock[i] <= 1'b0;
        lcnt[i]     <= 0;
      end else if (cfg_we[i]) begin
        pll_lock[i] <= 1'b0;
        lcnt[i]     <= lock_dly;
      end else if (lcnt[i] != 0) begin
        lcnt[i] <= lcnt[i] - 1;
        if (lcnt[i] == 1 && !(eth_stuck && i == 3)) pll_lock[i] <= 1'b1;
      end
    end
  end

  // Port monitor
  int   wr_cnt [4];
  int   v_word, v_core, v_gate, v_per, v_rst, v_eth;
  int   cyc, t_bus, d_bus, t_pg, d_per;
  bit   bus_seen, after_seen, rst_zero_seen;
  logic p_core_sel, p_per_sel;
  logic [2:0] p_gate;
  logic [6:0] p_rst;
  logic [31:0] exp_word [4];

  initial begin
    exp_word[0] = W_CORE & 32'h7FFF_FFFF;
    exp_word[1] = W_DDR  & 32'h7FFF_FFFF;
    exp_word[2] = W_PER  & 32'h7FFF_FFFF;
    exp_word[3] = W_ETH  & 32'h7FFF_FFFF;
  end

  task automatic clr_mon();
    @(posedge clk);
    for (int i = 0; i < 4; i++) wr_cnt[i] = 0;
    v_word = 0; v_core = 0; v_gate = 0; v_per = 0; v_rst = 0; v_eth = 0;
    bus_seen = 0; after_seen = 0; d_bus = -1; d_per = -1; t_pg = 0; rst_zero_seen = 0;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (cfg_we[i]) begin
          wr_cnt[i] = wr_cnt[i] + 1;
          if (cfg_data != exp_word[i]) v_word = v_word + 1;
        end
      end
      if (cfg_we[0] && !core_sel) v_core = v_core + 1;
      if (!core_sel && p_core_sel && !pll_lock[0]) v_core = v_core + 1;
      if (cfg_we[1] && (pll_gate[0] || dev_rst_n != 7'd0)) v_gate = v_gate + 1;
      if (cfg_we[3] && pll_gate[2]) v_gate = v_gate + 1;
      for (int k = 0; k < 3; k++)
        if (pll_gate[k] && !p_gate[k] && !pll_lock[k+1]) v_gate = v_gate + 1;
      if (cfg_we[2] && !per_sel) v_per = v_per + 1;
      if (!per_sel && p_per_sel && !pll_gate[1]) v_per = v_per + 1;
      if (pll_gate[1] && !p_gate[1]) t_pg = cyc;
      if (!per_sel && p_per_sel) d_per = cyc - t_pg;
      if (dev_rst_n == 7'd0) rst_zero_seen = 1;
      if (dev_rst_n[1] && !p_rst[1] && !p_rst[0]) v_rst = v_rst + 1;
      if (dev_rst_n[1] && !p_rst[1]) begin bus_seen = 1; t_bus = cyc; end
      if (bus_seen && !after_seen && cyc > t_bus &&
          ((per_sel && !p_per_sel) || cfg_we != 4'd0 || dev_rst_n[5])) begin
        after_seen = 1; d_bus = cyc - t_bus;
      end
      if (dev_rst_n[5] && !p_rst[5] && pll_present[1] && !pll_gate[2]) v_eth = v_eth + 1;
    end
    p_core_sel = core_sel; p_per_sel = per_sel; p_gate = pll_gate; p_rst = dev_rst_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc = 0; rst_n = 1'b0; start = 1'b0; pll_present = 6'b111111;
    lock_dly = 3; eth_stuck = 0;
    p_core_sel = 0; p_per_sel = 0; p_gate = 0; p_rst = 0;
    clr_mon();
    apply_reset();
    @(negedge clk);
    // R1 reset state
    chk(!done && !err, "R1 done/err", {done, err}, 0);
    chk(!core_sel && !per_sel, "R1 selects", {core_sel, per_sel}, 0);
    chk(pll_gate == 3'd0, "R1 gates", pll_gate, 0);
    chk(dev_rst_n == 7'd0, "R1 resets", dev_rst_n, 0);
    chk(cfg_we == 4'd0, "R1 write strobe", cfg_we, 0);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      rst_n = 1'b0;
      pll_present = VEC[v].mask;
      lock_dly    = VEC[v].dly;
      apply_reset();
      clr_mon();
      pulse_start();
      wait_end();
      @(negedge clk);
      chk(done && !err, "R12 done after run", {done, err}, 2);
      for (int i = 0; i < 4; i++)
        chk(wr_cnt[i] == int'(VEC[v].we[i]), "R5 write count", wr_cnt[i], VEC[v].we[i]);
      chk(v_word == 0, "R2 config word", v_word, 0);
      chk(pll_gate == VEC[v].gate, "R5 R6 gates", pll_gate, VEC[v].gate);
      chk(core_sel == VEC[v].cs, "R3 core select", core_sel, VEC[v].cs);
      chk(!per_sel, "R9 per select final", per_sel, 0);
      chk(dev_rst_n == RST_FINAL, "R8 R10 reset vector", dev_rst_n, RST_FINAL);
      chk(v_core == 0, "R3 core ordering", v_core, 0);
      chk(v_gate == 0, "R6 R7 gate ordering", v_gate, 0);
      chk(v_per == 0, "R9 per ordering", v_per, 0);
      chk(v_rst == 0, "R8 release order", v_rst, 0);
      chk(v_eth == 0, "R10 eth release", v_eth, 0);
      chk(d_bus >= DDR_SETTLE, "R8 settle cycles", d_bus, DDR_SETTLE);
      if (VEC[v].mask[3])
        chk(d_per >= PER_SETTLE, "R9 settle cycles", d_per, PER_SETTLE);
    end

    // R12: done holds while idle
    repeat (50) @(negedge clk);
    chk(done, "R12 done holds", done, 1);

    // R4 + R12: slow lock, start pulse while busy, re-run from idle with resets held high
    lock_dly = 150;
    clr_mon();
    pulse_start();
    @(negedge clk);
    chk(!done, "R12 done cleared on start", done, 0);
    repeat (100) @(negedge clk);
    chk(core_sel && wr_cnt[1] == 0, "R4 waits for lock", wr_cnt[1], 0);
    chk(dev_rst_n == RST_FINAL, "R4 no step before lock", dev_rst_n, RST_FINAL);
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(done && !err, "R12 re-run completes", {done, err}, 2);
    chk(wr_cnt[0] == 1, "R12 start while busy ignored", wr_cnt[0], 1);
    chk(rst_zero_seen, "R7 resets cleared on re-run", rst_zero_seen, 1);
    chk(v_gate == 0, "R7 resets low at DDR write", v_gate, 0);

    // R11: Ethernet PLL never locks
    lock_dly = 3; eth_stuck = 1;
    pll_present = 6'b111111;
    apply_reset();
    clr_mon();
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(err && !done, "R11 timeout error", {done, err}, 1);
    chk(!dev_rst_n[5] && !pll_gate[2], "R11 eth held", {dev_rst_n[5], pll_gate[2]}, 0);
    repeat (50) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    chk(err, "R11 error sticky", err, 1);
    chk(wr_cnt[3] == 1 && wr_cnt[0] == 1, "R11 halted no rewrite", wr_cnt[0], 1);
    chk(!done, "R11 no done after halt", done, 0);
    apply_reset();
    @(negedge clk);
    chk(!err, "R1 reset clears error", err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule